// File: doc/BRIEF.md
# PCI Interrupt Steering Unit

This block routes interrupt requests onto a bank of sixteen legacy ISA interrupt request lines. There are seven sources. Four are active-low PCI interrupt inputs (A, B, C and D). The other three are active-high interrupt inputs from the motherboard, called extra inputs 0, 1 and 2. Each source carries its own 4-bit steering code, which selects the target line or disables the source. When several sources are steered to the same line, their requests are OR-combined onto it.

Each PCI input has a polarity control. With the control cleared, the input is passed through unchanged for level-style use. With it set, the input is inverted for edge-style use. A pin-function register can take any extra input away from interrupt use, so its pad can serve another function. The same register also holds an enable bit for a status output.

Software reaches all of this through a byte-wide configuration port covering offsets 50h and 54h to 59h. Reserved fields read as zero and ignore writes.

Top module: `irq_steer_top`

## Requirements
- R1: After a synchronous reset, the following hold:
  - `irq_out` is 0, and every steering code is 0000.
  - All polarity bits, pin-function bits and `susp_stat_oe` are 0.
  - Offset 50h reads 04h, and offsets 54h to 59h read 00h.
- R2: Offset 54h holds the polarity controls. Bit 3 controls A, bit 2 controls B, bit 1 controls C and bit 0 controls D.
  - With the bit at 0, the source requests while its pin is low.
  - With the bit at 1, the source requests while its pin is high.
- R3: The steering codes sit at these offsets:
  - 55h: D in bits 7-4, extra input 0 in bits 3-0.
  - 56h: A in bits 7-4, B in bits 3-0.
  - 57h: C in bits 7-4, extra input 1 in bits 3-0.
  - 58h: extra input 2 in bits 3-0.
- R4: A steering code of 0000 disables its source. Codes 0010, 1000 and 1101 also route the source nowhere. Any other code n drives `irq_out[n]` while the source requests.
- R5: `irq_out` bits 0, 2, 8 and 13 are never driven high.
- R6: Requests from sources steered to the same line are OR-combined onto that line.
- R7: Offset 59h is the pin-function register.
  - Bits 0, 1 and 2 take extra inputs 0, 1 and 2 away from routing (1 = away) and appear on `alt_fn_sel[2:0]`.
  - Bit 3 drives `susp_stat_oe`, and that output changes only on a write to 59h or on reset.
- R8: Writes to reserved fields are ignored. Those fields are bits 7-4 of 54h, 58h and 59h, and the whole of 50h. Reserved fields read as 0, 50h always reads 04h, and unmapped offsets read 00h.
- R9: Timing is as follows:
  - `cfg_rdata` shows the register at `cfg_addr` one clock after the address is presented.
  - A change on an input pin reaches `irq_out` on the third rising edge after it.
  - A register write changes `irq_out` on the rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_int_n | input | 4 | PCI interrupts, active low; bit 0 = A, 1 = B, 2 = C, 3 = D |
| ext_irq | input | 3 | Extra motherboard interrupts, active high |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Write strobe for cfg_wdata at cfg_addr |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| irq_out | output | 16 | ISA interrupt request lines, registered |
| alt_fn_sel | output | 3 | Pin-function selects for extra inputs 0 to 2 |
| susp_stat_oe | output | 1 | Status output enable |

## Verification
Two events can land on the same clock edge. One is a software write that re-steers a source. The other is a request that is already asserted and settled on that source. The bench holds PCI A active on one line, then rewrites its code to another line. It samples `irq_out` between every pair of edges. The old line must stay up through the write edge, and the new line alone must be up one edge later, with no cycle that shows both lines or neither. The same one-edge rule is checked when a pin-function bit is set under a live extra-input request.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int PCI_N   = 4;
  localparam int EXT_N   = 3;
  localparam int SRC_N   = PCI_N + EXT_N;
  localparam int CODE_W  = 4;
  localparam int LINE_N  = 1 << CODE_W;
  localparam int BYTE_W  = 8;

  // configuration offsets
  localparam logic [7:0] OFS_RSVD  = 8'h50;
  localparam logic [7:0] OFS_POL   = 8'h54;
  localparam logic [7:0] OFS_RT_DX = 8'h55;
  localparam logic [7:0] OFS_RT_AB = 8'h56;
  localparam logic [7:0] OFS_RT_CX = 8'h57;
  localparam logic [7:0] OFS_RT_X2 = 8'h58;
  localparam logic [7:0] OFS_PINFN = 8'h59;
  localparam logic [7:0] RSVD_RST  = 8'h04;

  // source numbering
  localparam int SRC_A  = 0;
  localparam int SRC_B  = 1;
  localparam int SRC_C  = 2;
  localparam int SRC_D  = 3;
  localparam int SRC_X0 = 4;
  localparam int SRC_X1 = 5;
  localparam int SRC_X2 = 6;

  typedef logic [CODE_W-1:0] route_code_t;

  typedef struct packed {
    logic [SRC_N-1:0][CODE_W-1:0] route;
    logic [PCI_N-1:0]             pol_inv;
    logic [EXT_N-1:0]             alt_sel;
    logic                         susp_oe;
  } steer_cfg_t;

  // a code drives a line only if it is non-zero and not one of the holes
  function automatic logic code_drives(input route_code_t c);
    return (c != 4'd0) && (c != 4'd2) && (c != 4'd8) && (c != 4'd13);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_steer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output steer_cfg_t        cfg
);

  localparam int NIB = DATA_W / 2;

  steer_cfg_t         cfg_q;
  logic [DATA_W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr) begin
      unique case (8'(addr))
        OFS_POL: begin
          for (int i = 0; i < PCI_N; i++) cfg_q.pol_inv[i] <= wdata[PCI_N-1-i];
        end
        OFS_RT_DX: begin
          cfg_q.route[SRC_D]  <= wdata[DATA_W-1:NIB];
          cfg_q.route[SRC_X0] <= wdata[NIB-1:0];
        end
        OFS_RT_AB: begin
          cfg_q.route[SRC_A]  <= wdata[DATA_W-1:NIB];
          cfg_q.route[SRC_B]  <= wdata[NIB-1:0];
        end
        OFS_RT_CX: begin
          cfg_q.route[SRC_C]  <= wdata[DATA_W-1:NIB];
          cfg_q.route[SRC_X1] <= wdata[NIB-1:0];
        end
        OFS_RT_X2: begin
          cfg_q.route[SRC_X2] <= wdata[NIB-1:0];
        end
        OFS_PINFN: begin
          cfg_q.alt_sel <= wdata[EXT_N-1:0];
          cfg_q.susp_oe <= wdata[EXT_N];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (8'(addr))
      OFS_RSVD:  rd_mux = DATA_W'(RSVD_RST);
      OFS_POL: begin
        for (int i = 0; i < PCI_N; i++) rd_mux[PCI_N-1-i] = cfg_q.pol_inv[i];
      end
      OFS_RT_DX: rd_mux = {cfg_q.route[SRC_D], cfg_q.route[SRC_X0]};
      OFS_RT_AB: rd_mux = {cfg_q.route[SRC_A], cfg_q.route[SRC_B]};
      OFS_RT_CX: rd_mux = {cfg_q.route[SRC_C], cfg_q.route[SRC_X1]};
      OFS_RT_X2: rd_mux = {{NIB{1'b0}}, cfg_q.route[SRC_X2]};
      OFS_PINFN: rd_mux = {{(DATA_W-EXT_N-1){1'b0}}, cfg_q.susp_oe, cfg_q.alt_sel};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic invert,
  input  logic enable,
  output logic req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   active;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{ACTIVE_LOW}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign active = ~sync_q[SYNC_STAGES-1];
    end else begin : g_high
      assign active = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign req = enable & (active ^ invert);

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_steer_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SRC_N-1:0]             req,
  input  logic [SRC_N-1:0][CODE_W-1:0] route,
  output logic [LINE_N-1:0]            irq
);

  logic [LINE_N-1:0] irq_nxt;

  generate
    for (genvar k = 0; k < LINE_N; k++) begin : g_line
      logic [SRC_N-1:0] hit;
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
        assign hit[s] = req[s] && (route[s] == CODE_W'(k)) && code_drives(CODE_W'(k));
      end
      assign irq_nxt[k] = |hit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_nxt;
  end

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        pci_int_n,
  input  logic [2:0]        ext_irq,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [15:0]       irq_out,
  output logic [2:0]        alt_fn_sel,
  output logic              susp_stat_oe
);

  steer_cfg_t       cfg;
  logic [SRC_N-1:0] req;

  irq_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (cfg_addr),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  generate
    for (genvar i = 0; i < PCI_N; i++) begin : g_pci
      irq_src_cond #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .pin    (pci_int_n[i]),
        .invert (cfg.pol_inv[i]),
        .enable (1'b1),
        .req    (req[i])
      );
    end
    for (genvar j = 0; j < EXT_N; j++) begin : g_ext
      irq_src_cond #(.SYNC_STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b0)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .pin    (ext_irq[j]),
        .invert (1'b0),
        .enable (~cfg.alt_sel[j]),
        .req    (req[PCI_N+j])
      );
    end
  endgenerate

  irq_route_xbar u_xbar (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .route (cfg.route),
    .irq   (irq_out)
  );

  assign alt_fn_sel   = cfg.alt_sel;
  assign susp_stat_oe = cfg.susp_oe;

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [15:0]       irq_out,
  input logic              susp_stat_oe
);

  // R1: the first cycle after reset shows no request on any line
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_out == 16'h0);

  // R5: lines 0, 2, 8 and 13 stay low
  a_r5_holes_low: assert property (@(posedge clk) disable iff (rst)
    !irq_out[0] && !irq_out[2] && !irq_out[8] && !irq_out[13]);

  // R8: the reserved register at 50h always reads 04h
  a_r8_rsvd_const: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_addr) == ADDR_W'(8'h50)) |-> cfg_rdata == DATA_W'(8'h04));

  // R8: the upper nibble of 54h, 58h and 59h reads zero
  a_r8_rsvd_nibble: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cfg_addr) == ADDR_W'(8'h54) || $past(cfg_addr) == ADDR_W'(8'h58)
                     || $past(cfg_addr) == ADDR_W'(8'h59))) |-> cfg_rdata[7:4] == 4'h0);

  // R7: the status enable only moves on a write to 59h
  a_r7_oe_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(cfg_wr) && $past(cfg_addr) == ADDR_W'(8'h59))) |-> $stable(susp_stat_oe));

endmodule

bind irq_steer_top irq_steer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_addr     (cfg_addr),
  .cfg_wr       (cfg_wr),
  .cfg_rdata    (cfg_rdata),
  .irq_out      (irq_out),
  .susp_stat_oe (susp_stat_oe)
);

// File: tb/test_irq_steer_top.sv
`timescale 1ns/1ps
module test_irq_steer_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pci_int_n = 4'hF;
  logic [2:0]  ext_irq = 3'h0;
  logic [7:0]  cfg_addr = 8'h00;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_out;
  logic [2:0]  alt_fn_sel;
  logic        susp_stat_oe;

  int checks = 0;
  int errors = 0;

  // shadow configuration, source order A,B,C,D,X0,X1,X2
  logic [3:0] sh_pol;           // index = source A..D
  logic [3:0] sh_route [7];
  logic [2:0] sh_alt;
  logic       sh_oe;

  always #4 clk = ~clk;

  irq_steer_top i_irq_steer_top (
    .clk(clk), .rst(rst), .pci_int_n(pci_int_n), .ext_irq(ext_irq),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out), .alt_fn_sel(alt_fn_sel),
    .susp_stat_oe(susp_stat_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [7:0] sh_byte(input logic [7:0] a);
    case (a)
      8'h50: return 8'h04;
      8'h54: return {4'h0, sh_pol[0], sh_pol[1], sh_pol[2], sh_pol[3]};
      8'h55: return {sh_route[3], sh_route[4]};
      8'h56: return {sh_route[0], sh_route[1]};
      8'h57: return {sh_route[2], sh_route[5]};
      8'h58: return {4'h0, sh_route[6]};
      8'h59: return {4'h0, sh_oe, sh_alt};
      default: return 8'h00;
    endcase
  endfunction

  task automatic push_cfg();
    for (int a = 8'h54; a <= 8'h59; a++) wr_reg(8'(a), sh_byte(8'(a)));
  endtask

  task automatic clear_shadow();
    sh_pol = '0; sh_alt = '0; sh_oe = 1'b0;
    for (int s = 0; s < 7; s++) sh_route[s] = 4'h0;
  endtask

  function automatic logic [15:0] expect_irq(input logic [3:0] pn, input logic [2:0] ex);
    logic [15:0] r;
    logic        act;
    r = '0;
    for (int s = 0; s < 7; s++) begin
      if (s < 4) act = (~pn[s]) ^ sh_pol[s];
      else       act = ex[s-4] & ~sh_alt[s-4];
      if (act && sh_route[s] != 0 && sh_route[s] != 2 && sh_route[s] != 8 && sh_route[s] != 13)
        r[sh_route[s]] = 1'b1;
    end
    return r;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    clear_shadow();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    check("R1 irq_out", irq_out, 16'h0);
    check("R1 alt_fn_sel", 16'(alt_fn_sel), 16'h0);
    check("R1 susp_stat_oe", 16'(susp_stat_oe), 16'h0);
    for (int a = 8'h54; a <= 8'h59; a++) begin
      rd_reg(8'(a), rd);
      check($sformatf("R1 read %h", a), 16'(rd), 16'h0);
    end
    rd_reg(8'h50, rd);
    check("R1 read 50", 16'(rd), 16'h04);

    // R8: reserved writes and unmapped offsets
    wr_reg(8'h50, 8'h00); rd_reg(8'h50, rd); check("R8 50 write ignored", 16'(rd), 16'h04);
    wr_reg(8'h54, 8'hFF); rd_reg(8'h54, rd); check("R8 54 masked", 16'(rd), 16'h0F);
    wr_reg(8'h58, 8'hFF); rd_reg(8'h58, rd); check("R8 58 masked", 16'(rd), 16'h0F);
    wr_reg(8'h59, 8'hF8); rd_reg(8'h59, rd); check("R8 59 masked", 16'(rd), 16'h08);
    check("R7 susp_stat_oe set", 16'(susp_stat_oe), 16'h1);
    wr_reg(8'h60, 8'hAA); rd_reg(8'h60, rd); check("R8 unmapped", 16'(rd), 16'h00);
    wr_reg(8'h56, 8'hA5); rd_reg(8'h56, rd); check("R3 56 readback", 16'(rd), 16'hA5);
    wr_reg(8'h55, 8'h3C); rd_reg(8'h55, rd); check("R3 55 readback", 16'(rd), 16'h3C);
    wr_reg(8'h57, 8'h9E); rd_reg(8'h57, rd); check("R3 57 readback", 16'(rd), 16'h9E);
    clear_shadow(); push_cfg();
    check("R7 susp_stat_oe cleared", 16'(susp_stat_oe), 16'h0);

    // R3 R4 R5: every source through every code
    pci_int_n = 4'h0; ext_irq = 3'h7;
    for (int s = 0; s < 7; s++) begin
      for (int c = 0; c < 16; c++) begin
        clear_shadow();
        sh_route[s] = 4'(c);
        push_cfg(); settle();
        check($sformatf("R4 src%0d code%0d", s, c), irq_out, expect_irq(pci_int_n, ext_irq));
        check("R5 holes low", irq_out & 16'h2105, 16'h0);
      end
    end

    // R2: all polarity settings against all PCI pin patterns
    clear_shadow();
    sh_route[0] = 4'd3; sh_route[1] = 4'd4; sh_route[2] = 4'd5; sh_route[3] = 4'd9;
    ext_irq = 3'h0;
    for (int p = 0; p < 16; p++) begin
      sh_pol = 4'(p); push_cfg();
      for (int n = 0; n < 16; n++) begin
        pci_int_n = 4'(n); settle();
        check($sformatf("R2 pol%h pins%h", p, n), irq_out, expect_irq(pci_int_n, ext_irq));
      end
    end

    // R6: all sources on one line
    clear_shadow();
    for (int s = 0; s < 7; s++) sh_route[s] = 4'd11;
    push_cfg();
    for (int n = 0; n < 128; n++) begin
      pci_int_n = ~n[3:0]; ext_irq = n[6:4]; settle();
      check($sformatf("R6 merge %0d", n), irq_out, (n != 0) ? 16'h0800 : 16'h0);
    end

    // R7: pin-function selects against extra input patterns
    clear_shadow();
    sh_route[4] = 4'd10; sh_route[5] = 4'd12; sh_route[6] = 4'd15;
    pci_int_n = 4'hF;
    for (int a = 0; a < 8; a++) begin
      sh_alt = 3'(a); push_cfg();
      check("R7 alt_fn_sel", 16'(alt_fn_sel), 16'(a));
      for (int e = 0; e < 8; e++) begin
        ext_irq = 3'(e); settle();
        check($sformatf("R7 alt%0d ext%0d", a, e), irq_out, expect_irq(pci_int_n, ext_irq));
      end
    end

    // R9: pin latency, three rising edges
    clear_shadow(); sh_route[0] = 4'd3; push_cfg();
    pci_int_n = 4'hF; ext_irq = 3'h0; settle();
    pci_int_n = 4'hE;
    @(negedge clk); check("R9 pin edge1", irq_out, 16'h0);
    @(negedge clk); check("R9 pin edge2", irq_out, 16'h0);
    @(negedge clk); check("R9 pin edge3", irq_out, 16'h0008);

    // R9: re-steer under a live request, one edge after the write
    cfg_addr = 8'h56; cfg_wdata = 8'h40; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    check("R9 write edge old line", irq_out, 16'h0008);
    @(negedge clk); check("R9 write next edge new line", irq_out, 16'h0010);

    // R7 R9: pin-function set under a live extra request
    wr_reg(8'h55, 8'h07); ext_irq = 3'h1; settle();
    check("R7 x0 live", irq_out, 16'h0090);
    cfg_addr = 8'h59; cfg_wdata = 8'h01; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    check("R7 alt write edge", irq_out, 16'h0090);
    @(negedge clk); check("R7 alt next edge", irq_out, 16'h0010);

    // R1: reset in mid-traffic
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check("R1 reset again irq", irq_out, 16'h0);
    rd_reg(8'h56, rd); check("R1 reset again 56", 16'(rd), 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule